// File: doc/BRIEF.md
# Wraparound Register File with Multi-Word Access

This block is the operand store of a 16-bit processor data path. It holds 24 words of 16 bits. Entries 0 to 15 are the general registers that instructions name. Entries 16 to 23 are scratch words that only internal control may touch. The block has two read ports and one write port. All three work in the same clock cycle and do not interfere with each other.

An operand may be one, two or three words wide. A wide access is carried out as a run of 16-bit transfers, one per clock, starting at the lowest-numbered register. Register indices wrap inside the bank the access started in. In the general bank, register 15 is followed by register 0. In the scratch bank, entry 23 is followed by entry 16. Each port carries a privilege bit. A software-mode access that names a scratch entry is refused and flagged.

Top module: `regfile_wrap`

## Requirements
- R1: After reset, every entry reads as zero. All three ready outputs are high, and every done and illegal output is low.
- R2: A single-word write places its data in the addressed entry. Either read port can then return that data, for general entries 0..15 and for scratch entries 16..23 in internal mode (privilege bit 0).
- R3: A request is accepted on a clock edge at which its port is ready. A port given width code n (0 = 16 bits, 1 = 32 bits, 2 = 48 bits) performs n+1 transfers on the following n+1 edges. It shows ready low from the accept edge until the edge of its last transfer, and raises done for exactly one cycle after that last transfer.
- R4: Bits 16k+15..16k of a port's 48-bit data lane map to register (base+k), wrapped modulo 16 in the general bank or to 16..23 in the scratch bank. Lanes above the access width read as zero.
- R5: A software-mode access (privilege bit 1) to an address of 16 or above performs no transfer. It raises that port's illegal output for one cycle after the accept edge, and the port stays ready.
- R6: An address of 24 or above in any mode, or width code 3, is refused in the same way as R5.
- R7: When the write port and a read port transfer the same register on the same edge, the read returns the value held before that write.
- R8: The two read ports and the write port, each given its own request in the same cycle, each complete with its own correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ra_req | input | 1 | Read port A request |
| ra_addr | input | 5 | Read port A base register |
| ra_width | input | 2 | Read port A width code |
| ra_sw | input | 1 | Read port A software-mode bit |
| ra_ready | output | 1 | Read port A idle, may accept |
| ra_done | output | 1 | Read port A data valid pulse |
| ra_illegal | output | 1 | Read port A refused request pulse |
| ra_data | output | 48 | Read port A assembled lanes |
| rb_req | input | 1 | Read port B request |
| rb_addr | input | 5 | Read port B base register |
| rb_width | input | 2 | Read port B width code |
| rb_sw | input | 1 | Read port B software-mode bit |
| rb_ready | output | 1 | Read port B idle, may accept |
| rb_done | output | 1 | Read port B data valid pulse |
| rb_illegal | output | 1 | Read port B refused request pulse |
| rb_data | output | 48 | Read port B assembled lanes |
| wr_req | input | 1 | Write port request |
| wr_addr | input | 5 | Write port base register |
| wr_width | input | 2 | Write port width code |
| wr_sw | input | 1 | Write port software-mode bit |
| wr_data | input | 48 | Write data lanes |
| wr_ready | output | 1 | Write port idle, may accept |
| wr_done | output | 1 | Write port completion pulse |
| wr_illegal | output | 1 | Write port refused request pulse |

## Verification
The bench builds the block with its default parameters: 16 general entries, 8 scratch entries, 16-bit words and a three-word maximum. That configuration is small enough to sweep completely. Every entry is written and read through both read ports. Every general base is exercised with two- and three-word accesses, which reaches the 15-to-0 wrap from every offset, and every scratch base is exercised with a two-word access, which reaches the 23-to-16 wrap. Refused requests, same-register write and read collisions, and fully concurrent use of all three ports are checked against a bench-side model of the 24 words.

// File: rtl/rf_wrap_pkg.sv
package rf_wrap_pkg;

    typedef enum logic [1:0] {
        RF_W16  = 2'd0,
        RF_W32  = 2'd1,
        RF_W48  = 2'd2,
        RF_WBAD = 2'd3
    } rf_width_e;

    // Successor of an index inside its own bank: general bank wraps to 0,
    // scratch bank wraps to its first entry.
    function automatic int rf_next_idx(int cur, int ngen, int nscr);
        if (cur < ngen) begin
            return (cur == ngen - 1) ? 0 : cur + 1;
        end
        return (cur == ngen + nscr - 1) ? ngen : cur + 1;
    endfunction

endpackage

// File: rtl/rf_wrap_store.sv
module rf_wrap_store #(
    parameter  int DW    = 16,
    parameter  int DEPTH = 24,
    parameter  int NRD   = 2,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [NRD-1:0][AW-1:0]   raddr,
    output logic [NRD-1:0][DW-1:0]   rdata
);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we && (int'(waddr) < DEPTH)) begin
            st_d.mem[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = (int'(raddr[p]) < DEPTH) ? st_q.mem[raddr[p]] : '0;
    end

    // R2: a write lands in the addressed word on the following cycle
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (int'(waddr) < DEPTH)) |=> (st_q.mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/rf_wrap_port.sv
module rf_wrap_port
    import rf_wrap_pkg::*;
#(
    parameter  int DW    = 16,
    parameter  int NGEN  = 16,
    parameter  int NSCR  = 8,
    parameter  int MAXW  = 3,
    parameter  bit IS_WR = 1'b0,
    localparam int DEPTH = NGEN + NSCR,
    localparam int AW    = $clog2(DEPTH),
    localparam int LW    = (MAXW > 1) ? $clog2(MAXW) : 1,
    localparam int BW    = MAXW * DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic [AW-1:0]   addr,
    input  rf_width_e       width,
    input  logic            sw,
    input  logic [BW-1:0]   wdata,
    input  logic [DW-1:0]   rword,
    output logic            ready,
    output logic            illegal,
    output logic            done,
    output logic [BW-1:0]   rdata,
    output logic            xfer_en,
    output logic [AW-1:0]   xfer_addr,
    output logic [DW-1:0]   xfer_wdata
);

    typedef struct packed {
        logic            busy;
        logic            sw;
        logic [AW-1:0]   cur;
        logic [LW-1:0]   idx;
        logic [LW-1:0]   last;
        logic [BW-1:0]   lanes;
        logic            done;
        logic            illegal;
    } port_t;

    port_t st_d, st_q;
    logic  legal;

    always_comb begin
        legal = (int'(width) < MAXW) && (int'(addr) < DEPTH)
                && !(sw && (int'(addr) >= NGEN));
        st_d         = st_q;
        st_d.done    = 1'b0;
        st_d.illegal = 1'b0;
        if (!st_q.busy) begin
            if (req) begin
                if (legal) begin
                    st_d.busy  = 1'b1;
                    st_d.sw    = sw;
                    st_d.cur   = addr;
                    st_d.idx   = '0;
                    st_d.last  = LW'(width);
                    st_d.lanes = IS_WR ? wdata : '0;
                end else begin
                    st_d.illegal = 1'b1;
                end
            end
        end else begin
            if (!IS_WR) begin
                st_d.lanes[int'(st_q.idx)*DW +: DW] = rword;
            end
            if (st_q.idx == st_q.last) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
                st_d.cur = AW'(rf_next_idx(int'(st_q.cur), NGEN, NSCR));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready      = !st_q.busy;
    assign illegal    = st_q.illegal;
    assign done       = st_q.done;
    assign rdata      = st_q.lanes;
    assign xfer_en    = st_q.busy;
    assign xfer_addr  = st_q.cur;
    assign xfer_wdata = st_q.lanes[int'(st_q.idx)*DW +: DW];

    // R5: software request for a scratch entry is refused, port stays idle
    p_sw_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req && sw && (int'(addr) >= NGEN)) |=> (illegal && ready));

    // R4: software-mode transfers never leave the general bank
    p_gen_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_en && st_q.sw) |-> (int'(xfer_addr) < NGEN));

    // R3: done is a single-cycle pulse
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: a refusal always follows a request on the previous edge
    p_illegal_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> $past(req));

endmodule

// File: rtl/regfile_wrap.sv
module regfile_wrap
    import rf_wrap_pkg::*;
#(
    parameter  int DW    = 16,
    parameter  int NGEN  = 16,
    parameter  int NSCR  = 8,
    parameter  int MAXW  = 3,
    localparam int DEPTH = NGEN + NSCR,
    localparam int AW    = $clog2(DEPTH),
    localparam int BW    = MAXW * DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ra_req,
    input  logic [AW-1:0]   ra_addr,
    input  logic [1:0]      ra_width,
    input  logic            ra_sw,
    output logic            ra_ready,
    output logic            ra_done,
    output logic            ra_illegal,
    output logic [BW-1:0]   ra_data,
    input  logic            rb_req,
    input  logic [AW-1:0]   rb_addr,
    input  logic [1:0]      rb_width,
    input  logic            rb_sw,
    output logic            rb_ready,
    output logic            rb_done,
    output logic            rb_illegal,
    output logic [BW-1:0]   rb_data,
    input  logic            wr_req,
    input  logic [AW-1:0]   wr_addr,
    input  logic [1:0]      wr_width,
    input  logic            wr_sw,
    input  logic [BW-1:0]   wr_data,
    output logic            wr_ready,
    output logic            wr_done,
    output logic            wr_illegal
);

    localparam int NRD = 2;

    logic [NRD-1:0]            rd_req, rd_sw, rd_ready, rd_done, rd_illegal;
    logic [NRD-1:0][AW-1:0]    rd_addr, rd_xaddr;
    logic [NRD-1:0][1:0]       rd_width;
    logic [NRD-1:0][BW-1:0]    rd_data;
    logic [NRD-1:0][DW-1:0]    rd_word;
    logic [NRD-1:0]            rd_xen_unused;
    logic [NRD-1:0][DW-1:0]    rd_xw_unused;

    logic                      w_xen;
    logic [AW-1:0]             w_xaddr;
    logic [DW-1:0]             w_xword;
    logic [BW-1:0]             wr_rdata_unused;

    assign rd_req   = {rb_req, ra_req};
    assign rd_sw    = {rb_sw, ra_sw};
    assign rd_addr  = {rb_addr, ra_addr};
    assign rd_width = {rb_width, ra_width};

    for (genvar p = 0; p < NRD; p++) begin : g_rdport
        rf_wrap_port #(
            .DW(DW), .NGEN(NGEN), .NSCR(NSCR), .MAXW(MAXW), .IS_WR(1'b0)
        ) i_port (
            .clk        (clk),
            .rst_n      (rst_n),
            .req        (rd_req[p]),
            .addr       (rd_addr[p]),
            .width      (rf_width_e'(rd_width[p])),
            .sw         (rd_sw[p]),
            .wdata      ('0),
            .rword      (rd_word[p]),
            .ready      (rd_ready[p]),
            .illegal    (rd_illegal[p]),
            .done       (rd_done[p]),
            .rdata      (rd_data[p]),
            .xfer_en    (rd_xen_unused[p]),
            .xfer_addr  (rd_xaddr[p]),
            .xfer_wdata (rd_xw_unused[p])
        );
    end

    rf_wrap_port #(
        .DW(DW), .NGEN(NGEN), .NSCR(NSCR), .MAXW(MAXW), .IS_WR(1'b1)
    ) i_wport (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (wr_req),
        .addr       (wr_addr),
        .width      (rf_width_e'(wr_width)),
        .sw         (wr_sw),
        .wdata      (wr_data),
        .rword      ('0),
        .ready      (wr_ready),
        .illegal    (wr_illegal),
        .done       (wr_done),
        .rdata      (wr_rdata_unused),
        .xfer_en    (w_xen),
        .xfer_addr  (w_xaddr),
        .xfer_wdata (w_xword)
    );

    rf_wrap_store #(
        .DW(DW), .DEPTH(DEPTH), .NRD(NRD)
    ) i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (w_xen),
        .waddr (w_xaddr),
        .wdata (w_xword),
        .raddr (rd_xaddr),
        .rdata (rd_word)
    );

    assign ra_ready   = rd_ready[0];
    assign ra_done    = rd_done[0];
    assign ra_illegal = rd_illegal[0];
    assign ra_data    = rd_data[0];
    assign rb_ready   = rd_ready[1];
    assign rb_done    = rd_done[1];
    assign rb_illegal = rd_illegal[1];
    assign rb_data    = rd_data[1];

    // R3: a busy write port raises no refusal
    p_wr_busy_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ready |-> !wr_illegal);

endmodule

// File: tb/test_regfile_wrap.sv
module test_regfile_wrap;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ra_req = 0, rb_req = 0, wr_req = 0;
    logic [4:0]  ra_addr = 0, rb_addr = 0, wr_addr = 0;
    logic [1:0]  ra_width = 0, rb_width = 0, wr_width = 0;
    logic        ra_sw = 0, rb_sw = 0, wr_sw = 0;
    logic [47:0] wr_data = 0;
    logic        ra_ready, ra_done, ra_illegal;
    logic        rb_ready, rb_done, rb_illegal;
    logic        wr_ready, wr_done, wr_illegal;
    logic [47:0] ra_data, rb_data;

    int checks = 0;
    int errors = 0;
    logic [15:0] model [24];

    always #4 clk = ~clk;

    regfile_wrap i_regfile_wrap (
        .clk(clk), .rst_n(rst_n),
        .ra_req(ra_req), .ra_addr(ra_addr), .ra_width(ra_width), .ra_sw(ra_sw),
        .ra_ready(ra_ready), .ra_done(ra_done), .ra_illegal(ra_illegal), .ra_data(ra_data),
        .rb_req(rb_req), .rb_addr(rb_addr), .rb_width(rb_width), .rb_sw(rb_sw),
        .rb_ready(rb_ready), .rb_done(rb_done), .rb_illegal(rb_illegal), .rb_data(rb_data),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_width(wr_width), .wr_sw(wr_sw),
        .wr_data(wr_data), .wr_ready(wr_ready), .wr_done(wr_done), .wr_illegal(wr_illegal)
    );

    function automatic int nxt(int c);
        if (c < 16) return (c == 15) ? 0 : c + 1;
        return (c == 23) ? 16 : c + 1;
    endfunction

    function automatic bit legal(int a, int w, bit sw);
        return (w < 3) && (a < 24) && !(sw && a >= 16);
    endfunction

    function automatic logic [47:0] expect_lanes(int a, int w);
        logic [47:0] r = '0;
        int c = a;
        for (int k = 0; k <= w; k++) begin
            r[16*k +: 16] = model[c];
            c = nxt(c);
        end
        return r;
    endfunction

    task automatic chk(string tag, logic [47:0] act, logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(int a, int w, bit sw, logic [47:0] d, string tag);
        int c;
        wr_addr = 5'(a); wr_width = 2'(w); wr_sw = sw; wr_data = d; wr_req = 1;
        @(posedge clk); @(negedge clk);
        wr_req = 0;
        if (!legal(a, w, sw)) begin
            chk({tag, " write refused"}, 48'(wr_illegal), 48'd1);
            chk({tag, " write port stays ready"}, 48'(wr_ready), 48'd1);
        end else begin
            chk("R3 write busy after accept", 48'(wr_ready), 48'd0);
            repeat (w + 1) @(negedge clk);
            chk("R3 write done pulse", 48'(wr_done), 48'd1);
            chk("R3 write ready again", 48'(wr_ready), 48'd1);
            c = a;
            for (int k = 0; k <= w; k++) begin
                model[c] = d[16*k +: 16];
                c = nxt(c);
            end
        end
    endtask

    task automatic do_read(bit pb, int a, int w, bit sw, string tag);
        logic [47:0] got;
        logic        dn, il;
        if (pb) begin rb_addr = 5'(a); rb_width = 2'(w); rb_sw = sw; rb_req = 1; end
        else    begin ra_addr = 5'(a); ra_width = 2'(w); ra_sw = sw; ra_req = 1; end
        @(posedge clk); @(negedge clk);
        ra_req = 0; rb_req = 0;
        if (!legal(a, w, sw)) begin
            il = pb ? rb_illegal : ra_illegal;
            chk({tag, " read refused"}, 48'(il), 48'd1);
            chk({tag, " read port ready"}, 48'(pb ? rb_ready : ra_ready), 48'd1);
            @(negedge clk);
            chk({tag, " no done after refusal"}, 48'(pb ? rb_done : ra_done), 48'd0);
        end else begin
            repeat (w + 1) @(negedge clk);
            dn  = pb ? rb_done : ra_done;
            got = pb ? rb_data : ra_data;
            chk("R3 read done pulse", 48'(dn), 48'd1);
            chk(tag, got, expect_lanes(a, w));
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] old5;
        logic [47:0] oldw, newd;
        for (int i = 0; i < 24; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready lines", {45'd0, ra_ready, rb_ready, wr_ready}, 48'd7);
        chk("R1 done/illegal low",
            {42'd0, ra_done, rb_done, wr_done, ra_illegal, rb_illegal, wr_illegal}, 48'd0);
        for (int i = 0; i < 24; i++) begin
            do_read(i[0], i, 0, 1'b0, "R1 entry zero after reset");
        end

        // R2 single-word sweep over every entry, both read ports
        for (int i = 0; i < 24; i++) begin
            do_write(i, 0, (i < 16), 48'(16'(i * 16'h0901) ^ 16'h3C5A), "R2");
        end
        for (int i = 0; i < 24; i++) begin
            do_read(1'b0, i, 0, (i < 16), "R2 single read port A");
            do_read(1'b1, i, 0, 1'b0,     "R2 single read port B");
        end

        // R4 wide accesses from every general base, wrap 15 -> 0
        for (int b = 0; b < 16; b++) begin
            for (int w = 1; w <= 2; w++) begin
                newd = {16'(b * 16'h0313 + w), 16'(16'hA000 | b), 16'(w * 16'h1111 ^ b)};
                do_write(b, w, 1'b1, newd, "R4");
                do_read(1'b0, b, w, 1'b1, "R4 wide general read");
                do_read(1'b1, (b + w) % 16, 0, 1'b1, "R4 wrapped last word");
            end
        end
        // R4 scratch bank wrap 23 -> 16, internal mode
        for (int b = 16; b < 24; b++) begin
            do_write(b, 1, 1'b0, {16'h0, 16'(16'h5500 + b), 16'(16'h7700 + b)}, "R4");
            do_read(1'b1, b, 1, 1'b0, "R4 wide scratch read");
        end
        do_read(1'b0, 23, 2, 1'b0, "R4 scratch triple wraps");

        // R5 software mode may not touch scratch
        for (int i = 16; i < 24; i++) begin
            do_write(i, 0, 1'b1, 48'hDEAD, "R5");
            do_read(1'b1, i, 0, 1'b0, "R5 scratch unchanged");
        end
        do_read(1'b0, 20, 0, 1'b1, "R5");
        // R6 out-of-range address or bad width
        do_write(24, 0, 1'b0, 48'hBEEF, "R6");
        do_write(3, 3, 1'b0, 48'hBEEF, "R6");
        do_read(1'b0, 3, 0, 1'b0, "R6 entry 3 unchanged");
        do_read(1'b1, 31, 0, 1'b0, "R6");
        do_read(1'b0, 2, 3, 1'b1, "R6");

        // R7 same-register write and read in one cycle return old value
        old5 = model[5];
        wr_addr = 5; wr_width = 0; wr_sw = 1; wr_data = 48'h0000_0000_1234; wr_req = 1;
        ra_addr = 5; ra_width = 0; ra_sw = 1; ra_req = 1;
        @(posedge clk); @(negedge clk);
        wr_req = 0; ra_req = 0;
        @(negedge clk);
        chk("R7 single collision old value", ra_data, 48'(old5));
        model[5] = 16'h1234;
        do_read(1'b1, 5, 0, 1'b1, "R7 new value after collision");

        oldw = expect_lanes(14, 2);
        newd = 48'h9999_8888_7777;
        wr_addr = 14; wr_width = 2; wr_sw = 1; wr_data = newd; wr_req = 1;
        rb_addr = 14; rb_width = 2; rb_sw = 1; rb_req = 1;
        @(posedge clk); @(negedge clk);
        wr_req = 0; rb_req = 0;
        repeat (3) @(negedge clk);
        chk("R7 wide collision old lanes", rb_data, oldw);
        model[14] = 16'h7777; model[15] = 16'h8888; model[0] = 16'h9999;

        // R8 all three ports at once on distinct registers
        newd = 48'h0000_4242_2424;
        oldw = expect_lanes(8, 1);
        wr_addr = 2; wr_width = 1; wr_sw = 1; wr_data = newd; wr_req = 1;
        ra_addr = 8; ra_width = 1; ra_sw = 1; ra_req = 1;
        rb_addr = 18; rb_width = 0; rb_sw = 0; rb_req = 1;
        @(posedge clk); @(negedge clk);
        wr_req = 0; ra_req = 0; rb_req = 0;
        @(negedge clk);
        chk("R8 port B single result", rb_data, 48'(model[18]));
        @(negedge clk);
        chk("R8 port A pair result", ra_data, oldw);
        chk("R8 write done", 48'(wr_done), 48'd1);
        model[2] = 16'h2424; model[3] = 16'h4242;
        do_read(1'b0, 2, 1, 1'b1, "R8 written pair");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule